// File: doc/BRIEF.md
# Transmit Packet Buffer Manager

This block manages buffer memory for the transmit path of a network controller. Memory is handed out in fixed-size pages, and each buffer is known by a small packet number. The host sends one command at a time on a strobed command port. It can ask for a buffer of N bytes, queue a packet number for sending, free a packet's pages, acknowledge a finished transmission, switch transmit on or off, and clear the error flag. When an allocation succeeds, the block reports the packet number and sets a done flag. The host can poll that flag or mask it through to an interrupt line.

Queued packet numbers wait in a transmit FIFO. They are handed to the MAC one at a time, only while transmit is enabled. Each finished transmission, with its success bit, goes into a completion FIFO. While that FIFO holds anything, the transmit interrupt stays high. With auto-release on, a packet's pages return to the pool as soon as it is sent successfully. Otherwise the host frees them itself. A failed send switches transmit off, so the host can switch it back on and queue the same packet again.

Top module: `pktbuf_mgr`

## Requirements
- R1: After reset: alloc_done=0, alloc_irq=0, txq_empty=1, cmp_empty=1, cmp_head all-ones, tx_irq=0, tx_en=0, mac_req_valid=0, cmd_err=0, free_pages=NUM_PAGES.
- R2: Command op 1 (allocate) with length N takes max(1, ceil(N/PAGE_BYTES)) pages. Two rising edges after the command is sampled, alloc_done=1, alloc_result holds the lowest unallocated packet number, and free_pages has dropped by the page count.
- R3: When fewer free pages exist than a pending request needs, alloc_done stays 0. The request is granted on the edge after enough pages have been freed.
- R4: alloc_irq equals alloc_done AND alloc_irq_mask. An allocate command clears alloc_done on the edge that samples it.
- R5: Command op 2 (enqueue) on an allocated packet number pushes that number into the transmit FIFO, and txq_empty falls on the same edge.
- R6: A packet number moves from the transmit FIFO to mac_req_valid/mac_req_pkt only while tx_en=1, in FIFO order. The request holds, with the same number, until it is accepted by mac_req_ready. Op 5 sets tx_en and op 6 clears it.
- R7: A mac_done pulse pushes {mac_done_ok, mac_done_pkt} into the completion FIFO. cmp_head and cmp_head_ok show the oldest entry, tx_irq = NOT cmp_empty, and an empty FIFO reads all-ones.
- R8: Command op 4 (transmit acknowledge) pops the head of the completion FIFO.
- R9: Command op 3 (release) on an allocated packet returns all its pages to free_pages and marks the number unallocated.
- R10: With auto_release=1, a successful completion frees that packet's pages on the same edge. A failed completion frees nothing.
- R11: A failed completion clears tx_en. With auto_release=0, no completion frees pages, and a packet that failed can be enabled again and requeued.
- R12: Enqueue or release of an unallocated packet, enqueue into a full transmit FIFO, acknowledge with an empty completion FIFO, and completion into a full completion FIFO each have no effect and set the sticky cmd_err. Op 7 clears cmd_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 alloc, 2 enqueue, 3 release, 4 tx ack, 5 tx on, 6 tx off, 7 error clear) |
| cmd_len | input | LEN_W | Byte count for allocate |
| cmd_pkt | input | PKT_W | Packet number for enqueue/release |
| alloc_irq_mask | input | 1 | Routes alloc_done to alloc_irq |
| auto_release | input | 1 | Free pages on successful completion |
| alloc_done | output | 1 | Allocation finished |
| alloc_result | output | PKT_W | Packet number of last allocation |
| alloc_irq | output | 1 | Masked allocation interrupt |
| free_pages | output | PGC_W | Number of free pages |
| txq_empty | output | 1 | Transmit FIFO empty |
| tx_en | output | 1 | Transmit enable state |
| mac_req_valid | output | 1 | Packet offered to MAC |
| mac_req_pkt | output | PKT_W | Offered packet number |
| mac_req_ready | input | 1 | MAC accepts the offered packet |
| mac_done | input | 1 | Transmission finished pulse |
| mac_done_pkt | input | PKT_W | Finished packet number |
| mac_done_ok | input | 1 | Transmission succeeded |
| cmp_empty | output | 1 | Completion FIFO empty |
| cmp_head | output | PKT_W | Oldest completed packet number |
| cmp_head_ok | output | 1 | Success bit of oldest completion |
| tx_irq | output | 1 | Transmit interrupt |
| cmd_err | output | 1 | Sticky command error |

## Verification
The bench uses the default parameters: 8 pages of 256 bytes, 3-bit packet numbers and FIFOs 8 deep. With a pool this small, one 1500-byte request after two earlier allocations runs out of pages. That makes the stall-then-grant path of R3 easy to reach, and a single release can fill the pool back up to its limit. Lengths of 0, 256 and 300 bytes cover the one-page minimum and the rounding boundary of the page calculation.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALLOC  = 3'd1,
    OP_ENQ    = 3'd2,
    OP_REL    = 3'd3,
    OP_TXACK  = 3'd4,
    OP_TXON   = 3'd5,
    OP_TXOFF  = 3'd6,
    OP_ERRCLR = 3'd7
  } pbm_op_e;
endpackage

// File: rtl/pbm_fifo.sv
module pbm_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '1 : mem[rd_ptr];

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R12
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> !empty); // R5
endmodule

// File: rtl/pbm_page_alloc.sv
module pbm_page_alloc #(
  parameter int NUM_PAGES = 8,
  parameter int PKT_W     = 3,
  parameter int PGC_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [PGC_W-1:0]      req_pages,
  input  logic                  rel_a_valid,
  input  logic [PKT_W-1:0]      rel_a_pkt,
  input  logic                  rel_b_valid,
  input  logic [PKT_W-1:0]      rel_b_pkt,
  output logic [(1<<PKT_W)-1:0] owned,
  output logic                  alloc_done,
  output logic [PKT_W-1:0]      alloc_pkt,
  output logic [PGC_W-1:0]      free_pages
);
  localparam int NUM_PKTS = 1 << PKT_W;

  logic [PGC_W-1:0] pg_tbl [NUM_PKTS];
  logic             pend_valid;
  logic [PGC_W-1:0] pend_pages;
  logic             slot_found;
  logic [PKT_W-1:0] slot_idx;
  logic             grant;
  logic             free_a, free_b;
  logic [PGC_W:0]   freed_sum;

  // lowest unallocated packet number
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!owned[i]) begin
        slot_found = 1'b1;
        slot_idx   = PKT_W'(i);
      end
    end
  end

  assign grant  = pend_valid && !req_valid && slot_found &&
                  (free_pages >= pend_pages);
  assign free_a = rel_a_valid && owned[rel_a_pkt];
  assign free_b = rel_b_valid && owned[rel_b_pkt] &&
                  !(free_a && (rel_a_pkt == rel_b_pkt));

  always_comb begin
    freed_sum = '0;
    if (free_a) freed_sum = freed_sum + (PGC_W+1)'(pg_tbl[rel_a_pkt]);
    if (free_b) freed_sum = freed_sum + (PGC_W+1)'(pg_tbl[rel_b_pkt]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_pages <= '0;
      alloc_done <= 1'b0;
      alloc_pkt  <= '0;
      free_pages <= PGC_W'(NUM_PAGES);
    end else begin
      if (req_valid) begin
        pend_valid <= 1'b1;
        pend_pages <= req_pages;
        alloc_done <= 1'b0;
      end else if (grant) begin
        pend_valid <= 1'b0;
        alloc_done <= 1'b1;
        alloc_pkt  <= slot_idx;
      end
      free_pages <= PGC_W'((PGC_W+1)'(free_pages) + freed_sum -
                           (grant ? (PGC_W+1)'(pend_pages) : '0));
    end
  end

  generate
    for (genvar p = 0; p < NUM_PKTS; p++) begin : g_pkt
      always_ff @(posedge clk) begin
        if (rst) begin
          owned[p]  <= 1'b0;
          pg_tbl[p] <= '0;
        end else if (grant && slot_idx == PKT_W'(p)) begin
          owned[p]  <= 1'b1;
          pg_tbl[p] <= pend_pages;
        end else if ((free_a && rel_a_pkt == PKT_W'(p)) ||
                     (free_b && rel_b_pkt == PKT_W'(p))) begin
          owned[p]  <= 1'b0;
          pg_tbl[p] <= '0;
        end
      end
    end
  endgenerate

  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !alloc_done); // R4
  AST_GRANT_OWNED: assert property (@(posedge clk) disable iff (rst)
    $rose(alloc_done) |-> owned[alloc_pkt]); // R2
  AST_PEND_WAIT: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !req_valid && free_pages < pend_pages) |=> !alloc_done); // R3
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    free_pages <= PGC_W'(NUM_PAGES)); // R9
endmodule

// File: rtl/pbm_tx_sched.sv
module pbm_tx_sched #(
  parameter int PKT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_on,
  input  logic             en_off,
  input  logic             fail,
  input  logic             q_empty,
  input  logic [PKT_W-1:0] q_head,
  input  logic             mac_ready,
  output logic             q_pop,
  output logic             tx_en,
  output logic             req_valid,
  output logic [PKT_W-1:0] req_pkt
);
  assign q_pop = tx_en && !q_empty && !req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en     <= 1'b0;
      req_valid <= 1'b0;
      req_pkt   <= '0;
    end else begin
      if (fail)        tx_en <= 1'b0;
      else if (en_off) tx_en <= 1'b0;
      else if (en_on)  tx_en <= 1'b1;

      if (q_pop) begin
        req_valid <= 1'b1;
        req_pkt   <= q_head;
      end else if (req_valid && mac_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  AST_TX_GATE: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !req_valid) |=> !req_valid); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mac_ready) |=> (req_valid && $stable(req_pkt))); // R6
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (rst)
    fail |=> !tx_en); // R11
endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr #(
  parameter int NUM_PAGES  = 8,
  parameter int PAGE_BYTES = 256,
  parameter int PKT_W      = 3,
  parameter int LEN_W      = 11,
  parameter int TXQ_DEPTH  = 8,
  parameter int CMP_DEPTH  = 8,
  parameter int PGC_W      = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [PKT_W-1:0] cmd_pkt,
  input  logic             alloc_irq_mask,
  input  logic             auto_release,
  output logic             alloc_done,
  output logic [PKT_W-1:0] alloc_result,
  output logic             alloc_irq,
  output logic [PGC_W-1:0] free_pages,
  output logic             txq_empty,
  output logic             tx_en,
  output logic             mac_req_valid,
  output logic [PKT_W-1:0] mac_req_pkt,
  input  logic             mac_req_ready,
  input  logic             mac_done,
  input  logic [PKT_W-1:0] mac_done_pkt,
  input  logic             mac_done_ok,
  output logic             cmp_empty,
  output logic [PKT_W-1:0] cmp_head,
  output logic             cmp_head_ok,
  output logic             tx_irq,
  output logic             cmd_err
);
  import pbm_pkg::*;

  localparam int NUM_PKTS   = 1 << PKT_W;
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
  localparam int SUM_W      = LEN_W + 1;

  pbm_op_e op;
  logic    is_alloc, is_enq, is_rel, is_ack, is_on, is_off, is_clr;

  assign op       = pbm_op_e'(cmd_op);
  assign is_alloc = cmd_valid && (op == OP_ALLOC);
  assign is_enq   = cmd_valid && (op == OP_ENQ);
  assign is_rel   = cmd_valid && (op == OP_REL);
  assign is_ack   = cmd_valid && (op == OP_TXACK);
  assign is_on    = cmd_valid && (op == OP_TXON);
  assign is_off   = cmd_valid && (op == OP_TXOFF);
  assign is_clr   = cmd_valid && (op == OP_ERRCLR);

  // page count: round up, minimum one page
  logic [SUM_W-1:0] len_up;
  logic [SUM_W-1:0] pages_raw;
  logic [PGC_W-1:0] req_pages;

  assign len_up    = SUM_W'(cmd_len) + SUM_W'(PAGE_BYTES - 1);
  assign pages_raw = len_up >> PAGE_SHIFT;
  always_comb begin
    if (pages_raw == '0)                   req_pages = PGC_W'(1);
    else if (pages_raw > SUM_W'(NUM_PAGES)) req_pages = '1;
    else                                   req_pages = PGC_W'(pages_raw);
  end

  logic [NUM_PKTS-1:0] owned;
  logic                rel_ok, auto_free;
  logic                txq_full, txq_push, txq_pop;
  logic [PKT_W-1:0]    txq_head;
  logic                cmp_full, cmp_push;
  logic [PKT_W:0]      cmp_word;
  logic                enq_bad, rel_bad, ack_bad, cmp_bad;

  assign rel_ok    = is_rel && owned[cmd_pkt];
  assign auto_free = mac_done && mac_done_ok && auto_release;

  pbm_page_alloc #(
    .NUM_PAGES(NUM_PAGES),
    .PKT_W    (PKT_W),
    .PGC_W    (PGC_W)
  ) i_alloc (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (is_alloc),
    .req_pages  (req_pages),
    .rel_a_valid(rel_ok),
    .rel_a_pkt  (cmd_pkt),
    .rel_b_valid(auto_free),
    .rel_b_pkt  (mac_done_pkt),
    .owned      (owned),
    .alloc_done (alloc_done),
    .alloc_pkt  (alloc_result),
    .free_pages (free_pages)
  );

  assign enq_bad  = is_enq && (!owned[cmd_pkt] || txq_full);
  assign txq_push = is_enq && !enq_bad;

  pbm_fifo #(.W(PKT_W), .DEPTH(TXQ_DEPTH)) i_txq (
    .clk  (clk),
    .rst  (rst),
    .push (txq_push),
    .wdata(cmd_pkt),
    .pop  (txq_pop),
    .empty(txq_empty),
    .full (txq_full),
    .head (txq_head)
  );

  pbm_tx_sched #(.PKT_W(PKT_W)) i_sched (
    .clk      (clk),
    .rst      (rst),
    .en_on    (is_on),
    .en_off   (is_off),
    .fail     (mac_done && !mac_done_ok),
    .q_empty  (txq_empty),
    .q_head   (txq_head),
    .mac_ready(mac_req_ready),
    .q_pop    (txq_pop),
    .tx_en    (tx_en),
    .req_valid(mac_req_valid),
    .req_pkt  (mac_req_pkt)
  );

  assign cmp_bad  = mac_done && cmp_full;
  assign cmp_push = mac_done && !cmp_full;

  pbm_fifo #(.W(PKT_W + 1), .DEPTH(CMP_DEPTH)) i_cmpq (
    .clk  (clk),
    .rst  (rst),
    .push (cmp_push),
    .wdata({mac_done_ok, mac_done_pkt}),
    .pop  (is_ack),
    .empty(cmp_empty),
    .full (cmp_full),
    .head (cmp_word)
  );

  assign cmp_head    = cmp_word[PKT_W-1:0];
  assign cmp_head_ok = cmp_word[PKT_W];
  assign tx_irq      = !cmp_empty;
  assign alloc_irq   = alloc_done && alloc_irq_mask;

  assign rel_bad = is_rel && !owned[cmd_pkt];
  assign ack_bad = is_ack && cmp_empty;

  always_ff @(posedge clk) begin
    if (rst)                                          cmd_err <= 1'b0;
    else if (enq_bad || rel_bad || ack_bad || cmp_bad) cmd_err <= 1'b1;
    else if (is_clr)                                  cmd_err <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmd_err && !is_clr) |=> cmd_err); // R12
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (mac_done && !cmp_full) |=> tx_irq); // R7
  AST_REL_GONE: assert property (@(posedge clk) disable iff (rst)
    rel_ok |=> !owned[$past(cmd_pkt)]); // R9
endmodule

// File: tb/test_pktbuf_mgr.sv
module test_pktbuf_mgr;
  localparam int PKT_W = 3;
  localparam int LEN_W = 11;
  localparam int PGC_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd_op = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [PKT_W-1:0] cmd_pkt = '0;
  logic             alloc_irq_mask = 1'b0;
  logic             auto_release = 1'b0;
  logic             mac_req_ready = 1'b0;
  logic             mac_done = 1'b0;
  logic [PKT_W-1:0] mac_done_pkt = '0;
  logic             mac_done_ok = 1'b0;
  logic             alloc_done, alloc_irq, txq_empty, tx_en, mac_req_valid;
  logic             cmp_empty, cmp_head_ok, tx_irq, cmd_err;
  logic [PKT_W-1:0] alloc_result, mac_req_pkt, cmp_head;
  logic [PGC_W-1:0] free_pages;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pktbuf_mgr i_pktbuf_mgr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_pkt(cmd_pkt), .alloc_irq_mask(alloc_irq_mask),
    .auto_release(auto_release), .alloc_done(alloc_done),
    .alloc_result(alloc_result), .alloc_irq(alloc_irq), .free_pages(free_pages),
    .txq_empty(txq_empty), .tx_en(tx_en), .mac_req_valid(mac_req_valid),
    .mac_req_pkt(mac_req_pkt), .mac_req_ready(mac_req_ready),
    .mac_done(mac_done), .mac_done_pkt(mac_done_pkt), .mac_done_ok(mac_done_ok),
    .cmp_empty(cmp_empty), .cmp_head(cmp_head), .cmp_head_ok(cmp_head_ok),
    .tx_irq(tx_irq), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input int op, input int len, input int pkt);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_len   = LEN_W'(len);
    cmd_pkt   = PKT_W'(pkt);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = '0;
  endtask

  task automatic accept();
    mac_req_ready = 1'b1;
    @(negedge clk);
    mac_req_ready = 1'b0;
  endtask

  task automatic finish_tx(input int pkt, input bit ok);
    mac_done     = 1'b1;
    mac_done_pkt = PKT_W'(pkt);
    mac_done_ok  = ok;
    @(negedge clk);
    mac_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "alloc_done", alloc_done, 0);
    chk("R1", "alloc_irq", alloc_irq, 0);
    chk("R1", "txq_empty", txq_empty, 1);
    chk("R1", "cmp_empty", cmp_empty, 1);
    chk("R1", "cmp_head", cmp_head, 7);
    chk("R1", "tx_irq", tx_irq, 0);
    chk("R1", "tx_en", tx_en, 0);
    chk("R1", "mac_req_valid", mac_req_valid, 0);
    chk("R1", "cmd_err", cmd_err, 0);
    chk("R1", "free_pages", free_pages, 8);
  endtask

  task automatic t_alloc_basic();
    cmd(1, 300, 0);
    chk("R4", "done cleared by alloc", alloc_done, 0);
    step(1);
    chk("R2", "done 300B", alloc_done, 1);
    chk("R2", "result 300B", alloc_result, 0);
    chk("R2", "free after 2 pages", free_pages, 6);
    chk("R4", "irq masked", alloc_irq, 0);
    alloc_irq_mask = 1'b1;
    #1;
    chk("R4", "irq unmasked", alloc_irq, 1);
    cmd(1, 0, 0);
    chk("R4", "done cleared again", alloc_done, 0);
    chk("R4", "irq follows done", alloc_irq, 0);
    step(1);
    chk("R2", "result 0B", alloc_result, 1);
    chk("R2", "0B takes 1 page", free_pages, 5);
    alloc_irq_mask = 1'b0;
  endtask

  task automatic t_alloc_pending();
    cmd(1, 1500, 0);
    step(3);
    chk("R3", "stalled done", alloc_done, 0);
    chk("R3", "stalled free", free_pages, 5);
    cmd(3, 0, 0);
    chk("R9", "free after release", free_pages, 7);
    chk("R3", "not yet granted", alloc_done, 0);
    step(1);
    chk("R3", "granted", alloc_done, 1);
    chk("R3", "reuses slot 0", alloc_result, 0);
    chk("R3", "free after grant", free_pages, 1);
  endtask

  task automatic t_errors();
    cmd(2, 0, 5);
    chk("R12", "enqueue unowned err", cmd_err, 1);
    chk("R12", "enqueue unowned no push", txq_empty, 1);
    cmd(7, 0, 0);
    chk("R12", "err cleared", cmd_err, 0);
    cmd(3, 0, 6);
    chk("R12", "release unowned err", cmd_err, 1);
    chk("R12", "release unowned pages", free_pages, 1);
    cmd(7, 0, 0);
    cmd(4, 0, 0);
    chk("R12", "ack empty err", cmd_err, 1);
    chk("R12", "ack empty stays empty", cmp_empty, 1);
    step(2);
    chk("R12", "err sticky", cmd_err, 1);
    cmd(7, 0, 0);
    chk("R12", "err cleared again", cmd_err, 0);
  endtask

  task automatic t_tx_order();
    cmd(2, 0, 1);
    chk("R5", "txq not empty", txq_empty, 0);
    cmd(2, 0, 0);
    step(3);
    chk("R6", "no req while disabled", mac_req_valid, 0);
    cmd(5, 0, 0);
    chk("R6", "tx_en set", tx_en, 1);
    chk("R6", "req not yet", mac_req_valid, 0);
    step(1);
    chk("R6", "first req valid", mac_req_valid, 1);
    chk("R6", "first req pkt", mac_req_pkt, 1);
    step(2);
    chk("R6", "req held", mac_req_valid, 1);
    chk("R6", "req pkt held", mac_req_pkt, 1);
    accept();
    chk("R6", "req dropped after accept", mac_req_valid, 0);
    step(1);
    chk("R6", "second req", mac_req_valid, 1);
    chk("R6", "second pkt order", mac_req_pkt, 0);
    accept();
    chk("R6", "queue drained", txq_empty, 1);
  endtask

  task automatic t_complete_manual();
    auto_release = 1'b0;
    finish_tx(1, 1'b1);
    chk("R7", "cmp not empty", cmp_empty, 0);
    chk("R7", "tx_irq", tx_irq, 1);
    chk("R7", "head pkt", cmp_head, 1);
    chk("R7", "head ok", cmp_head_ok, 1);
    chk("R11", "manual keeps pages", free_pages, 1);
    finish_tx(0, 1'b1);
    chk("R7", "head still oldest", cmp_head, 1);
    cmd(4, 0, 0);
    chk("R8", "pop to second", cmp_head, 0);
    cmd(4, 0, 0);
    chk("R8", "empty after pops", cmp_empty, 1);
    chk("R7", "empty head ones", cmp_head, 7);
    chk("R7", "tx_irq low", tx_irq, 0);
    cmd(3, 0, 1);
    chk("R9", "manual release", free_pages, 2);
    chk("R9", "no error", cmd_err, 0);
  endtask

  task automatic t_fail_requeue();
    cmd(2, 0, 0);
    step(1);
    chk("R6", "req pkt0", mac_req_pkt, 0);
    accept();
    finish_tx(0, 1'b0);
    chk("R11", "fail clears tx_en", tx_en, 0);
    chk("R7", "fail status", cmp_head_ok, 0);
    chk("R11", "fail keeps pages", free_pages, 2);
    cmd(4, 0, 0);
    cmd(2, 0, 0);
    chk("R11", "requeue accepted", cmd_err, 0);
    step(2);
    chk("R11", "held while disabled", mac_req_valid, 0);
    cmd(5, 0, 0);
    step(1);
    chk("R11", "requeued req", mac_req_valid, 1);
    chk("R11", "requeued pkt", mac_req_pkt, 0);
    accept();
    finish_tx(0, 1'b1);
    chk("R11", "manual ok keeps pages", free_pages, 2);
    cmd(4, 0, 0);
  endtask

  task automatic t_auto();
    auto_release = 1'b1;
    cmd(2, 0, 0);
    step(1);
    accept();
    finish_tx(0, 1'b1);
    chk("R10", "auto frees", free_pages, 8);
    cmd(2, 0, 0);
    chk("R10", "freed pkt unowned", cmd_err, 1);
    cmd(7, 0, 0);
    cmd(4, 0, 0);
    cmd(1, 256, 0);
    step(1);
    chk("R2", "256B is one page", free_pages, 7);
    chk("R2", "result", alloc_result, 0);
    cmd(2, 0, 0);
    step(1);
    accept();
    finish_tx(0, 1'b0);
    chk("R10", "auto fail keeps pages", free_pages, 7);
    chk("R10", "auto fail clears tx_en", tx_en, 0);
    cmd(4, 0, 0);
    chk("R8", "cmp empty", cmp_empty, 1);
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_alloc_basic();
    t_alloc_pending();
    t_errors();
    t_tx_order();
    t_complete_manual();
    t_fail_requeue();
    t_auto();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule